// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator with two independent channels. Each channel has a counter in place of an analog timing network. A qualified trigger sets the channel's output at once and loads the counter with a period taken from a 16-bit input. The output then stays high for that many clock cycles. A further trigger during the pulse reloads the counter, so the pulse always ends one full period after the last trigger.

Each channel has two trigger inputs. One is qualified on its rising edge and the other on its falling edge, and each is gated by the level of the other. An active-low clear ends any pulse and blocks triggering while it is held low. All three inputs pass through two-flop synchronizers. Q and its complement are both registered.

Top module: `dual_oneshot`

## Requirements
- R1: While reset is asserted, and at the end of reset, every channel drives q_o low and q_n_o high.
- R2: A low-to-high change on trig_rise_i is a trigger when trig_fall_i is high and clear_n_i is high. q_o goes high at the third rising clock edge after the input change, counting the first edge that samples it as the first.
- R3: A high-to-low change on trig_fall_i is a trigger when trig_rise_i is low and clear_n_i is high. The latency is the same as in R2.
- R4: A rising edge on trig_rise_i while trig_fall_i is low does not trigger. A falling edge on trig_fall_i while trig_rise_i is high does not trigger.
- R5: After a single trigger, q_o stays high for exactly the number of clock cycles on the channel's slice of period_i, sampled when the trigger takes effect. A value of 0 acts as 1.
- R6: A trigger while q_o is high restarts the full period. Triggers on consecutive qualifying edges, two cycles apart, are all honoured.
- R7: Taking clear_n_i low ends a pulse: q_o is low from the third rising edge after the change, even if the period has not run out.
- R8: While clear_n_i is low, edges on either trigger input leave the outputs unchanged.
- R9: A trigger edge that reaches the logic in the same cycle that clear_n_i returns high is ignored.
- R10: q_n_o is always the complement of q_o.
- R11: The channels are independent. Channel k uses bit k of each control vector and bits [16k+15:16k] of period_i.
- R12: The delay from a trigger to q_o rising does not depend on the period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_rise_i | input | NCH | Rising-edge trigger, one bit per channel |
| trig_fall_i | input | NCH | Falling-edge trigger, one bit per channel |
| clear_n_i | input | NCH | Active-low clear, one bit per channel |
| period_i | input | NCH*PERIOD_W | Pulse length in cycles, one slice per channel |
| q_o | output | NCH | Pulse output |
| q_n_o | output | NCH | Complement of the pulse output |

## Verification
A single rising-input pulse and a single falling-input pulse show that each trigger path works alone. The same edges are also applied with the gating input at the wrong level, which shows whether the cross-gating is decoded. Retriggers spaced several cycles apart, and retriggers on every second cycle, show whether a trigger reloads the counter or is dropped while the pulse is running. Clear is exercised three ways: in the middle of a pulse, held low with triggers applied, and released in the same cycle as a trigger edge. Together these tell premature termination apart from inhibition and from the priority rule. A behavioural model compares both channels on every cycle, and measured pulse widths and latencies show whether the period is loaded correctly and whether the trigger-to-output delay is independent of the period.

// File: rtl/os_pkg.sv
package os_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
    logic clr;
  } os_ctl_t;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= '0;
        else     stg[gi] <= stg[gi-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
  import os_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  os_ctl_t cur_i,
  output logic    trig_o,
  output logic    clr_ok_o
);
  os_ctl_t prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur_i;
  end

  logic rise_edge, fall_edge, clr_stable;
  assign rise_edge  = cur_i.rise & ~prev.rise & cur_i.fall;
  assign fall_edge  = ~cur_i.fall & prev.fall & ~cur_i.rise;
  assign clr_stable = cur_i.clr & prev.clr;
  assign trig_o     = clr_stable & (rise_edge | fall_edge);
  assign clr_ok_o   = cur_i.clr;

  assert_clear_edge_R9: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(cur_i.clr));
  assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_i.rise && !prev.rise && !cur_i.fall && cur_i.rise) |-> !trig_o);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_ok_i,
  input  logic                trig_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                q_o,
  output logic                qn_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt, load_val;
  assign load_val = (period_i == '0) ? '0 : period_i - ONE;

  always_ff @(posedge clk) begin
    if (rst || !clr_ok_i) begin
      q_o  <= 1'b0;
      qn_o <= 1'b1;
      cnt  <= '0;
    end else if (trig_i) begin
      q_o  <= 1'b1;
      qn_o <= 1'b0;
      cnt  <= load_val;
    end else if (q_o && cnt == '0) begin
      q_o  <= 1'b0;
      qn_o <= 1'b1;
    end else if (q_o) begin
      cnt  <= cnt - ONE;
    end
  end

  assert_compl_R10: assert property (@(posedge clk) disable iff (rst)
    qn_o == ~q_o);
  assert_clear_low_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_ok_i |=> !q_o);
  assert_trig_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (trig_i && clr_ok_i) |=> q_o);
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(q_o) |-> $past(trig_i));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (q_o && cnt != '0 && clr_ok_i) |=> q_o);
  assert_end_R5: assert property (@(posedge clk) disable iff (rst)
    (q_o && cnt == '0 && !trig_i) |=> !q_o);
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
  import os_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          trig_rise_i,
  input  logic [NCH-1:0]          trig_fall_i,
  input  logic [NCH-1:0]          clear_n_i,
  input  logic [NCH*PERIOD_W-1:0] period_i,
  output logic [NCH-1:0]          q_o,
  output logic [NCH-1:0]          q_n_o
);
  localparam int unsigned CTL_W = $bits(os_ctl_t);

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      os_ctl_t raw, synced;
      logic    trig, clr_ok;

      assign raw = '{rise: trig_rise_i[ch], fall: trig_fall_i[ch], clr: clear_n_i[ch]};

      os_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
      );

      os_trig_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .cur_i    (synced),
        .trig_o   (trig),
        .clr_ok_o (clr_ok)
      );

      os_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr_ok_i (clr_ok),
        .trig_i   (trig),
        .period_i (period_i[ch*PERIOD_W +: PERIOD_W]),
        .q_o      (q_o[ch]),
        .qn_o     (q_n_o[ch])
      );
    end
  endgenerate
endmodule

// File: tb/sim_dual_oneshot.sv
module sim_dual_oneshot;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int PW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] rise_in = '0, fall_in = '1, clr_in = '1;
  logic [PW-1:0]  per [NCH];
  logic [NCH*PW-1:0] period_bus;
  logic [NCH-1:0] q, qn;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  assign period_bus = {per[1], per[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_oneshot #(.NCH(NCH), .PERIOD_W(PW)) u0 (
    .clk(clk), .rst(rst), .trig_rise_i(rise_in), .trig_fall_i(fall_in),
    .clear_n_i(clr_in), .period_i(period_bus), .q_o(q), .q_n_o(qn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: input history delayed by sampling depth
  logic [5:0] hist[$];
  bit mq [NCH];
  int rem [NCH];

  always @(posedge clk) begin
    if (rst) begin
      hist = {6'd0, 6'd0, 6'd0};
      for (int c = 0; c < NCH; c++) begin mq[c] = 0; rem[c] = 0; end
    end else begin
      hist.push_back({rise_in[1], fall_in[1], clr_in[1], rise_in[0], fall_in[0], clr_in[0]});
      while (hist.size() > 4) void'(hist.pop_front());
      for (int c = 0; c < NCH; c++) begin
        logic [2:0] cu, pv;
        bit t;
        int eff;
        cu = hist[hist.size()-3][3*c +: 3];
        pv = hist[hist.size()-4][3*c +: 3];
        t = cu[0] && pv[0] && ((cu[2] && !pv[2] && cu[1]) || (!cu[1] && pv[1] && !cu[2]));
        eff = (per[c] == 0) ? 1 : int'(per[c]);
        if (!cu[0]) begin mq[c] = 0; rem[c] = 0; end
        else if (t) begin mq[c] = 1; rem[c] = eff - 1; end
        else if (mq[c]) begin
          if (rem[c] == 0) mq[c] = 0; else rem[c]--;
        end
      end
    end
  end

  int run [NCH];
  int last_w [NCH];

  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        chk(q[c] == mq[c], cur_req, q[c], mq[c]);
        chk(qn[c] == ~q[c], "R10", qn[c], ~q[c]);
        if (q[c]) run[c]++;
        else if (run[c] > 0) begin last_w[c] = run[c]; run[c] = 0; end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rise(input int c);
    rise_in[c] = 1'b1; cyc(1); rise_in[c] = 1'b0;
  endtask

  task automatic pulse_fall(input int c);
    fall_in[c] = 1'b0; cyc(1); fall_in[c] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin per[c] = 16'd5; run[c] = 0; last_w[c] = 0; end
    cyc(3);
    cur_req = "R1";
    chk(q == 2'b00, "R1", q, 0);
    chk(qn == 2'b11, "R1", qn, 3);
    rst = 1'b0;
    cyc(4);

    // R2 single rising trigger, period 5
    cur_req = "R2";
    pulse_rise(0); cyc(12);
    chk(last_w[0] == 5, "R2", last_w[0], 5);

    // R3 falling trigger, period 7
    cur_req = "R3"; per[0] = 16'd7;
    pulse_fall(0); cyc(14);
    chk(last_w[0] == 7, "R3", last_w[0], 7);

    // R4 wrong gating level
    cur_req = "R4";
    fall_in[0] = 1'b0; cyc(4); rise_in[0] = 1'b1; cyc(6);
    chk(q[0] == 1'b0, "R4", q[0], 0);
    fall_in[0] = 1'b1; cyc(4); fall_in[0] = 1'b0; cyc(6);
    chk(q[0] == 1'b0, "R4", q[0], 0);
    rise_in[0] = 1'b0; fall_in[0] = 1'b1; cyc(6);
    chk(q[0] == 1'b0, "R4", q[0], 0);

    // R5 period 0 and 1
    cur_req = "R5"; per[0] = 16'd0;
    pulse_rise(0); cyc(8);
    chk(last_w[0] == 1, "R5", last_w[0], 1);
    per[0] = 16'd1; last_w[0] = 0;
    pulse_rise(0); cyc(8);
    chk(last_w[0] == 1, "R5", last_w[0], 1);

    // R6 retrigger spaced and back-to-back
    cur_req = "R6"; per[0] = 16'd10;
    pulse_rise(0); cyc(5); pulse_rise(0); cyc(24);
    chk(last_w[0] == 16, "R6", last_w[0], 16);
    per[0] = 16'd3;
    for (int i = 0; i < 3; i++) begin rise_in[0] = 1'b1; cyc(1); rise_in[0] = 1'b0; cyc(1); end
    cyc(10);
    chk(last_w[0] == 7, "R6", last_w[0], 7);

    // R7 clear mid-pulse
    cur_req = "R7"; per[0] = 16'd20;
    pulse_rise(0); cyc(6);
    chk(q[0] == 1'b1, "R7", q[0], 1);
    clr_in[0] = 1'b0; cyc(3);
    chk(q[0] == 1'b0, "R7", q[0], 0);
    clr_in[0] = 1'b1; cyc(25);
    chk(last_w[0] < 20, "R7", last_w[0], 19);

    // R8 triggers inhibited while clear low
    cur_req = "R8"; per[0] = 16'd4;
    clr_in[0] = 1'b0; cyc(4);
    pulse_rise(0); cyc(2); pulse_fall(0); cyc(6);
    chk(q[0] == 1'b0, "R8", q[0], 0);
    chk(qn[0] == 1'b1, "R8", qn[0], 1);

    // R9 trigger coincident with clear release
    cur_req = "R9";
    clr_in[0] = 1'b1; rise_in[0] = 1'b1; cyc(8);
    chk(q[0] == 1'b0, "R9", q[0], 0);
    rise_in[0] = 1'b0; cyc(2); rise_in[0] = 1'b1; cyc(3);
    chk(q[0] == 1'b1, "R9", q[0], 1);
    rise_in[0] = 1'b0; cyc(8);

    // R11 independent channels
    cur_req = "R11"; per[0] = 16'd9; per[1] = 16'd4;
    pulse_rise(1); cyc(2); pulse_fall(0); cyc(2);
    clr_in[1] = 1'b0; cyc(1); clr_in[1] = 1'b1; cyc(16);
    chk(last_w[0] == 9, "R11", last_w[0], 9);
    chk(last_w[1] == 4, "R11", last_w[1], 4);

    // R12 latency independent of period
    cur_req = "R12";
    per[0] = 16'd60000;
    rise_in[0] = 1'b1; cyc(2);
    chk(q[0] == 1'b0, "R12", q[0], 0);
    cyc(1);
    chk(q[0] == 1'b1, "R12", q[0], 1);
    rise_in[0] = 1'b0; clr_in[0] = 1'b0; cyc(4); clr_in[0] = 1'b1; cyc(4);
    per[0] = 16'd2;
    rise_in[0] = 1'b1; cyc(2);
    chk(q[0] == 1'b0, "R12", q[0], 0);
    cyc(1);
    chk(q[0] == 1'b1, "R12", q[0], 1);
    rise_in[0] = 1'b0; cyc(6);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule